// File: doc/BRIEF.md
# Real-time clock status flags and interrupt control

This block keeps the control and status bits of a real-time clock. A control register selects how often a temperature compensation cycle runs and whether an update event may raise the interrupt line. A status register holds three sticky flags: oscillator data loss, compensation stopped, and time update. Each flag is set by its hardware input and cleared only when software writes a zero to its bit. Writing a one to a flag bit does nothing.

A 2 Hz tick input is counted down to a one-cycle compensation strobe at the chosen interval. Any write to the control register restarts this count. The interrupt is an open-drain, active-low output. It is modelled as an output enable, `int_oe`, whose driven level is always zero. The enable stays high while the update flag is set and the update interrupt enable is on.

Top module: `rtc_status_ctrl`

## Requirements
- R1: After reset the control register reads 0x40 (interval code 01, interrupt enable 0). The status register reads 0x06: data loss and compensation stopped are set, and the update flag is clear. `int_oe` and `comp_strobe` are low.
- R2: The control register can be read and written at address 0x0F and at its mirror 0x1F. Bits 7:6 are the interval code and bit 5 is the update interrupt enable. Bits 4:0 always read as zero.
- R3: For interval codes 00, 01, 10 and 11, `comp_strobe` pulses for one cycle on every 1st, 4th, 20th and 60th tick respectively. The pulse appears in the cycle after the terminal tick is sampled.
- R4: Any write to the control register restarts the tick count from zero. The next strobe then comes only after a full interval of new ticks.
- R5: Each status flag keeps its value until a write to the status register carries a zero in that flag's bit. A one in that bit leaves the flag unchanged.
- R6: `osc_stop` sets the data-loss flag, `comp_halt` sets the compensation-stopped flag and `upd_evt` sets the update flag. If a set and a clearing write arrive in the same cycle, the set wins.
- R7: `int_oe` is high exactly while the update flag and the update interrupt enable are both 1. It falls after the update flag is cleared by a zero write.
- R8: The status register is at address 0x0E, with bit 2 for data loss, bit 1 for compensation stopped and bit 0 for the update flag. Its bits 7:3 read as zero, and every other address reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| tick | input | 1 | One-cycle pulse at 2 Hz |
| upd_evt | input | 1 | Time update event pulse |
| osc_stop | input | 1 | Oscillator stop detected |
| comp_halt | input | 1 | Temperature compensation halted |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| comp_strobe | output | 1 | One-cycle compensation strobe |
| int_oe | output | 1 | Interrupt pull-low enable (driven level is 0) |

## Verification
The strobe generator is swept over all four interval codes, with two full intervals of ticks for each. Every tick and every idle cycle after it is checked, which tells an off-by-one terminal count apart from a wrong code mapping. The flags are driven with writes of all ones, with single-bit zeros and with set-during-clear collisions, which separates clearing by a zero from writing the value directly. The interrupt is tried with the enable turned on while the flag is already pending, with writes of one to the flag and with a clear. A restart test writes the control register in the middle of an interval and confirms that the count starts again.

// File: rtl/rtcsf_pkg.sv
package rtcsf_pkg;
  localparam logic [7:0] CTRL_ADDR_A = 8'h0F;
  localparam logic [7:0] CTRL_ADDR_B = 8'h1F;
  localparam logic [7:0] STAT_ADDR   = 8'h0E;
  localparam int SEL_HI  = 7;
  localparam int SEL_LO  = 6;
  localparam int UIE_BIT = 5;
  localparam int F_UPD   = 0;
  localparam int F_COMP  = 1;
  localparam int F_LOSS  = 2;
  localparam int NFLAGS  = 3;
  localparam logic [1:0] SEL_RESET = 2'b01;

  // ticks per compensation interval for a tick rate of hz
  function automatic int interval_ticks(input logic [1:0] sel, input int hz);
    int t;
    case (sel)
      2'b00:   t = hz / 2;
      2'b01:   t = 2 * hz;
      2'b10:   t = 10 * hz;
      default: t = 30 * hz;
    endcase
    if (t < 1) t = 1;
    return t;
  endfunction
endpackage

// File: rtl/rtcsf_sticky_flag.sv
module rtcsf_sticky_flag #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic wr_zero,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= set | (q & ~wr_zero);
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !wr_zero) |=> q);
  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_zero && !set) |=> !q);
  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
endmodule

// File: rtl/rtcsf_interval_timer.sv
module rtcsf_interval_timer
  import rtcsf_pkg::*;
#(
  parameter int TICK_HZ = 2,
  parameter int CNT_W   = $clog2(30 * TICK_HZ + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       strobe
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             at_end;

  assign limit  = CNT_W'(interval_ticks(sel, TICK_HZ));
  assign at_end = (cnt >= limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else if (restart) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else begin
      strobe <= tick & at_end;
      if (tick) cnt <= at_end ? '0 : cnt + CNT_W'(1);
    end
  end

  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < limit);
  assert_strobe_from_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $past(tick));
  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0 && !strobe));
endmodule

// File: rtl/rtc_status_ctrl.sv
module rtc_status_ctrl
  import rtcsf_pkg::*;
#(
  parameter int TICK_HZ = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       upd_evt,
  input  logic       osc_stop,
  input  logic       comp_halt,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       comp_strobe,
  output logic       int_oe
);
  localparam logic [NFLAGS-1:0] FLAG_RST = NFLAGS'(3'b110);

  logic              ctrl_hit, stat_hit, ctrl_wr, stat_wr;
  logic [1:0]        sel_q;
  logic              uie_q;
  logic [NFLAGS-1:0] flag_set, flag_clr, flags;

  assign ctrl_hit = (addr == CTRL_ADDR_A) || (addr == CTRL_ADDR_B);
  assign stat_hit = (addr == STAT_ADDR);
  assign ctrl_wr  = wr_en & ctrl_hit;
  assign stat_wr  = wr_en & stat_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= SEL_RESET;
      uie_q <= 1'b0;
    end else if (ctrl_wr) begin
      sel_q <= wdata[SEL_HI:SEL_LO];
      uie_q <= wdata[UIE_BIT];
    end
  end

  always_comb begin
    flag_set         = '0;
    flag_set[F_UPD]  = upd_evt;
    flag_set[F_COMP] = comp_halt;
    flag_set[F_LOSS] = osc_stop;
  end

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    assign flag_clr[i] = stat_wr & ~wdata[i];
    rtcsf_sticky_flag #(.RESET_VAL(FLAG_RST[i])) u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (flag_set[i]),
      .wr_zero (flag_clr[i]),
      .q       (flags[i])
    );
  end

  rtcsf_interval_timer #(.TICK_HZ(TICK_HZ)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .sel     (sel_q),
    .restart (ctrl_wr),
    .strobe  (comp_strobe)
  );

  always_comb begin
    rdata = '0;
    if (ctrl_hit) begin
      rdata[SEL_HI:SEL_LO] = sel_q;
      rdata[UIE_BIT]       = uie_q;
    end else if (stat_hit) begin
      rdata[NFLAGS-1:0] = flags;
    end
  end

  assign int_oe = uie_q & flags[F_UPD];

  assert_ctrl_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |-> (rdata[4:0] == 5'd0));
  assert_int_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[F_UPD] && !upd_evt) |=> !int_oe);
  assert_int_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && uie_q && !ctrl_wr) |=> int_oe);
endmodule

// File: tb/rtc_status_ctrl_tb.sv
module rtc_status_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, upd_evt = 1'b0, osc_stop = 1'b0, comp_halt = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       comp_strobe, int_oe;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  rtc_status_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .upd_evt(upd_evt),
    .osc_stop(osc_stop), .comp_halt(comp_halt), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .comp_strobe(comp_strobe), .int_oe(int_oe)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  function automatic int exp_limit(input int code);
    if (code == 0) return 1;
    if (code == 1) return 4;
    if (code == 2) return 20;
    return 60;
  endfunction

  // pulse tick for one cycle; check strobe in the following cycle and one idle cycle
  task automatic tick_once(input string req, input logic exp_s);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(req, {7'd0, comp_strobe}, {7'd0, exp_s});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 ctrl", 8'h0F, 8'h40);
    rd("R1 ctrl mirror", 8'h1F, 8'h40);
    rd("R1 status", 8'h0E, 8'h06);
    chk("R1 int_oe", {7'd0, int_oe}, 8'h00);
    chk("R1 strobe", {7'd0, comp_strobe}, 8'h00);
    // R8 unmapped addresses
    rd("R8 addr 00", 8'h00, 8'h00);
    rd("R8 addr 10", 8'h10, 8'h00);
    rd("R8 addr 1E", 8'h1E, 8'h00);
    // R5 write one ignored, write zero clears
    wr(8'h0E, 8'hFF); rd("R5 ones ignored", 8'h0E, 8'h06);
    wr(8'h0E, 8'hFD); rd("R5 clear comp only", 8'h0E, 8'h04);
    wr(8'h0E, 8'h00); rd("R5 clear all", 8'h0E, 8'h00);
    // R6 set inputs
    osc_stop = 1'b1; @(negedge clk); osc_stop = 1'b0;
    rd("R6 osc_stop sets loss", 8'h0E, 8'h04);
    comp_halt = 1'b1; @(negedge clk); comp_halt = 1'b0;
    rd("R6 comp_halt sets", 8'h0E, 8'h06);
    osc_stop = 1'b1; wr(8'h0E, 8'h00); osc_stop = 1'b0;
    rd("R6 set beats clear", 8'h0E, 8'h04);
    wr(8'h0E, 8'h00); rd("R5 cleared", 8'h0E, 8'h00);
    // R2 control register and mirror
    wr(8'h1F, 8'hFF);
    rd("R2 via 0F", 8'h0F, 8'hE0);
    rd("R2 via 1F", 8'h1F, 8'hE0);
    wr(8'h0F, 8'h00);
    rd("R2 cleared", 8'h1F, 8'h00);
    // R7 interrupt
    upd_evt = 1'b1; @(negedge clk); upd_evt = 1'b0;
    rd("R6 upd_evt sets", 8'h0E, 8'h01);
    chk("R7 disabled", {7'd0, int_oe}, 8'h00);
    wr(8'h0F, 8'h20);
    chk("R7 enable with pending", {7'd0, int_oe}, 8'h01);
    wr(8'h0E, 8'h01);
    chk("R7 write one keeps", {7'd0, int_oe}, 8'h01);
    wr(8'h0E, 8'h00);
    chk("R7 cleared", {7'd0, int_oe}, 8'h00);
    upd_evt = 1'b1; @(negedge clk); upd_evt = 1'b0;
    chk("R7 event raises", {7'd0, int_oe}, 8'h01);
    wr(8'h0E, 8'h00);
    chk("R7 cleared again", {7'd0, int_oe}, 8'h00);
    // R3 sweep of interval codes
    for (int code = 0; code < 4; code++) begin
      int lim;
      lim = exp_limit(code);
      wr(8'h0F, 8'(code << 6));
      for (int i = 1; i <= 2 * lim; i++) begin
        tick_once("R3 tick", (i % lim) == 0);
        @(negedge clk);
        chk("R3 idle", {7'd0, comp_strobe}, 8'h00);
      end
    end
    // R4 restart on control write
    wr(8'h0F, 8'h40);
    for (int i = 0; i < 3; i++) tick_once("R4 before restart", 1'b0);
    wr(8'h1F, 8'h40);
    for (int i = 0; i < 3; i++) tick_once("R4 after restart", 1'b0);
    tick_once("R4 full interval", 1'b1);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule